// File: doc/BRIEF.md
# Shared Pin Function and Resource Router

This block governs a bank of shared pads, each of which can serve either as a display segment driver or as a general-purpose digital I/O. A small write-only configuration port sets four things: the function of each pad, the direction and output value of pads in digital mode, and a global enable that keeps the low group of pads from driving while software brings the system up. The segment waveforms themselves are produced elsewhere. This block only raises a per-pad segment-select flag that the segment driver uses.

A window of pads, plus one dedicated input-only pad, each carry a 3-bit routing code. The code steers the level on that pad to one of three internal resources: the clock of counter 0, the clock of counter 1, or a high-priority interrupt request. The level is read at the pad, so a pad that is driving still feeds its own output value to the resource it selects. When several pads pick the same resource, their levels are ORed together. Each resource line passes through a two-flop synchronizer before it leaves the block.

Top module: `pinbank_top`

## Requirements
- R1: A write to address 0 sets the function of each pad, with bit i for pad i. A 1 selects segment mode: `seg_sel[i]` is 1 and `pin_oe[i]` is 0. A 0 selects digital mode.
- R2: Address 1 holds the direction bits, where 1 means output. Address 2 holds the output values, which appear on `pin_do`. A pad at or above index 16 drives (`pin_oe` is 1) exactly when it is in digital mode with direction set to output.
- R3: `pin_oe[i]` and `seg_sel[i]` are never 1 in the same cycle.
- R4: Bits [2:0] of the data word select the routing code. For pads 2 through 11 the code is written at address 4+(i-2), and for the dedicated pad it is written at address 14. Code 2 drives `cnt0_clk`, code 3 drives `cnt1_clk` and code 4 drives `irq_hi`. Codes 0, 1, 5, 6 and 7 route nothing.
- R5: When several pads select the same resource, the resource output is the OR of their levels.
- R6: A change in a routed level appears on the resource output after exactly two rising clock edges.
- R7: Reset leaves the following state: every pad in digital mode, pads 0 to 15 set as outputs and the rest as inputs, output values 0, all routing codes 0, and the port enable (address 3, bit 0) at 0. Pads 0 to 15 never drive while the port enable is 0.
- R8: A pad in output mode feeds its own driven value (as seen at `pin_di`) to the resource it selects.
- R9: A pad in segment mode contributes nothing to routing. The dedicated pad always contributes according to its code.
- R10: Pads outside the range 2 to 11 have no routing code and never affect a resource output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 24 | Configuration write data |
| pin_di | input | 24 | Level sensed at each shared pad |
| ded_di | input | 1 | Level at the dedicated input-only pad |
| pin_oe | output | 24 | Per-pad output enable |
| pin_do | output | 24 | Per-pad output value |
| seg_sel | output | 24 | Per-pad segment-mode flag |
| cnt0_clk | output | 1 | Synchronized counter 0 clock |
| cnt1_clk | output | 1 | Synchronized counter 1 clock |
| irq_hi | output | 1 | Synchronized high-priority interrupt request |

## Verification
A wrong mode, direction or enable bit shows on `pin_oe`, `seg_sel` or `pin_do` in the cycle after the write. It also shows after reset with no write at all. A wrong routing code or a broken OR shows on a resource output two edges after the pad level changes. For that reason every routing check waits past the synchronizer and then samples. The bench loops driven values back onto `pin_di` the way a real pad would, so a fault in output tracking shows up as a resource output that stays silent.

// File: rtl/pinbank_pkg.sv
// Package: shared encodings for the shared pin bank.
// Assumes: routing codes are 3 bits wide; values outside the enum route nothing.
package pinbank_pkg;
    typedef enum logic [2:0] {
        RES_NONE = 3'd0,
        RES_RSVD = 3'd1,
        RES_CNT0 = 3'd2,
        RES_CNT1 = 3'd3,
        RES_IRQ  = 3'd4
    } res_code_e;

    localparam int RES_W = 3;
endpackage

// File: rtl/pinbank_cfg.sv
// Module: configuration registers of the shared pin bank.
// Holds the mode, direction, output data, port enable and routing codes.
// Assumes: single-cycle writes with no read path; only pads in
// [ROUTE_LO, ROUTE_HI] plus the dedicated pad own a routing register.
module pinbank_cfg #(
    parameter int NUM_PINS  = 24,
    parameter int LOW_GROUP = 16,
    parameter int ROUTE_LO  = 2,
    parameter int ROUTE_HI  = 11,
    parameter int ADDR_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [NUM_PINS-1:0] cfg_wdata,
    output logic [NUM_PINS-1:0] mode_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] data_q,
    output logic                port_en_q,
    output logic [2:0]          route_q [NUM_PINS],
    output logic [2:0]          ded_q
);
    localparam int ROUTE_CNT  = ROUTE_HI - ROUTE_LO + 1;
    localparam int A_MODE     = 0;
    localparam int A_DIR      = 1;
    localparam int A_DATA     = 2;
    localparam int A_PEN      = 3;
    localparam int A_ROUTE    = 4;
    localparam int A_DED      = A_ROUTE + ROUTE_CNT;
    localparam logic [NUM_PINS-1:0] DIR_RST =
        {{(NUM_PINS-LOW_GROUP){1'b0}}, {LOW_GROUP{1'b1}}};

    logic wr_mode, wr_dir, wr_data, wr_pen, wr_ded;

    // Decode the write strobes for the fixed registers.
    always_comb begin
        wr_mode = cfg_we && (cfg_addr == ADDR_W'(A_MODE));
        wr_dir  = cfg_we && (cfg_addr == ADDR_W'(A_DIR));
        wr_data = cfg_we && (cfg_addr == ADDR_W'(A_DATA));
        wr_pen  = cfg_we && (cfg_addr == ADDR_W'(A_PEN));
        wr_ded  = cfg_we && (cfg_addr == ADDR_W'(A_DED));
    end

    // Update mode, direction, data and port enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            dir_q     <= DIR_RST;
            data_q    <= '0;
            port_en_q <= 1'b0;
        end else begin
            if (wr_mode) mode_q    <= cfg_wdata;
            if (wr_dir)  dir_q     <= cfg_wdata;
            if (wr_data) data_q    <= cfg_wdata;
            if (wr_pen)  port_en_q <= cfg_wdata[0];
        end
    end

    // Update the dedicated pad routing code.
    always_ff @(posedge clk) begin
        if (!rst_n)      ded_q <= 3'd0;
        else if (wr_ded) ded_q <= cfg_wdata[2:0];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
        if (p >= ROUTE_LO && p <= ROUTE_HI) begin : g_reg
            localparam int A_ME = A_ROUTE + p - ROUTE_LO;
            logic [2:0] code_q;
            // Update this pad's routing code on a write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n) code_q <= 3'd0;
                else if (cfg_we && cfg_addr == ADDR_W'(A_ME)) code_q <= cfg_wdata[2:0];
            end
            assign route_q[p] = code_q;
        end else begin : g_none
            assign route_q[p] = 3'd0;
        end
    end
endmodule

// File: rtl/pinbank_mux.sv
// Module: per-pad function multiplexer.
// Forms output enable, output data, segment flag and the level seen by routing.
// Assumes: pads below LOW_GROUP are additionally gated by the port enable.
module pinbank_mux #(
    parameter int NUM_PINS  = 24,
    parameter int LOW_GROUP = 16
) (
    input  logic [NUM_PINS-1:0] mode,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] data,
    input  logic                port_en,
    input  logic [NUM_PINS-1:0] pin_di,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_do,
    output logic [NUM_PINS-1:0] seg_sel,
    output logic [NUM_PINS-1:0] dig_lvl
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        logic gate;
        if (p < LOW_GROUP) begin : g_low
            assign gate = port_en;
        end else begin : g_high
            assign gate = 1'b1;
        end
        // Combine mode, direction and gate into the pad's drive controls.
        always_comb begin
            seg_sel[p] = mode[p];
            pin_oe[p]  = !mode[p] && dir[p] && gate;
            pin_do[p]  = data[p];
            dig_lvl[p] = pin_di[p] && !mode[p];
        end
    end
endmodule

// File: rtl/pinbank_router.sv
// Module: resource router. ORs pad levels into the three resource lines
// according to each pad's 3-bit code.
// Assumes: non-routable pads arrive with code 0.
module pinbank_router
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [2:0]          code [NUM_PINS],
    input  logic                ded_lvl,
    input  logic [2:0]          ded_code,
    output logic [RES_W-1:0]    raw_res
);
    // Accumulate every pad that selects each resource.
    always_comb begin
        logic c0, c1, irq;
        c0  = ded_lvl && (ded_code == RES_CNT0);
        c1  = ded_lvl && (ded_code == RES_CNT1);
        irq = ded_lvl && (ded_code == RES_IRQ);
        for (int p = 0; p < NUM_PINS; p++) begin
            c0  = c0  | (lvl[p] && (code[p] == RES_CNT0));
            c1  = c1  | (lvl[p] && (code[p] == RES_CNT1));
            irq = irq | (lvl[p] && (code[p] == RES_IRQ));
        end
        raw_res = {irq, c1, c0};
    end
endmodule

// File: rtl/pinbank_sync.sv
// Module: two-flop synchronizer, WIDTH bits wide.
// Assumes: each bit is independent and quasi-static relative to clk.
module pinbank_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] s1;

    // Pass the input through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/pinbank_top.sv
// Module: shared pin function and resource router, top level.
// Wires config registers, per-pad mux, router and synchronizer together.
// Assumes: pin_di reflects the real pad level, including when a pad drives.
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int LOW_GROUP = 16,
    parameter int ROUTE_LO  = 2,
    parameter int ROUTE_HI  = 11,
    parameter int ADDR_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [NUM_PINS-1:0] cfg_wdata,
    input  logic [NUM_PINS-1:0] pin_di,
    input  logic                ded_di,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_do,
    output logic [NUM_PINS-1:0] seg_sel,
    output logic                cnt0_clk,
    output logic                cnt1_clk,
    output logic                irq_hi
);
    logic [NUM_PINS-1:0] mode_q, dir_q, data_q, dig_lvl;
    logic                port_en_q;
    logic [2:0]          route_q [NUM_PINS];
    logic [2:0]          ded_q;
    logic [RES_W-1:0]    raw_res, res_sync;

    pinbank_cfg #(
        .NUM_PINS(NUM_PINS), .LOW_GROUP(LOW_GROUP),
        .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mode_q(mode_q), .dir_q(dir_q), .data_q(data_q),
        .port_en_q(port_en_q), .route_q(route_q), .ded_q(ded_q)
    );

    pinbank_mux #(.NUM_PINS(NUM_PINS), .LOW_GROUP(LOW_GROUP)) u_mux (
        .mode(mode_q), .dir(dir_q), .data(data_q), .port_en(port_en_q),
        .pin_di(pin_di), .pin_oe(pin_oe), .pin_do(pin_do),
        .seg_sel(seg_sel), .dig_lvl(dig_lvl)
    );

    pinbank_router #(.NUM_PINS(NUM_PINS)) u_router (
        .lvl(dig_lvl), .code(route_q), .ded_lvl(ded_di),
        .ded_code(ded_q), .raw_res(raw_res)
    );

    pinbank_sync #(.WIDTH(RES_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_res), .q(res_sync)
    );

    assign cnt0_clk = res_sync[0];
    assign cnt1_clk = res_sync[1];
    assign irq_hi   = res_sync[2];
endmodule

// File: rtl/pinbank_checker.sv
// Module: property checker for pinbank_top, attached by bind.
// Assumes: it sees the internal port enable and the raw resource vector.
module pinbank_checker #(
    parameter int NUM_PINS  = 24,
    parameter int LOW_GROUP = 16,
    parameter int ADDR_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] seg_sel,
    input logic                port_en_q,
    input logic [2:0]          raw_res,
    input logic [2:0]          res_sync
);
    logic [1:0] cyc;

    // Count the edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    assert_oe_not_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & seg_sel) == '0);

    assert_low_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_q |-> (pin_oe[LOW_GROUP-1:0] == '0));

    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(cfg_we) && $past(cfg_addr) == '0) |-> $stable(seg_sel));

    assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (res_sync == $past(raw_res, 2)));
endmodule

bind pinbank_top pinbank_checker #(
    .NUM_PINS(NUM_PINS), .LOW_GROUP(LOW_GROUP), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .pin_oe(pin_oe), .seg_sel(seg_sel), .port_en_q(port_en_q),
    .raw_res(raw_res), .res_sync(res_sync)
);

// File: tb/pinbank_top_tb.sv
module pinbank_top_tb;
    localparam int N = 24;
    logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, ded_ext = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [N-1:0] cfg_wdata = '0, ext = '0, pin_di;
    logic [N-1:0] pin_oe, pin_do, seg_sel;
    logic cnt0_clk, cnt1_clk, irq_hi;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    // Pads that drive read back their own value, the rest read the external level.
    assign pin_di = (pin_oe & pin_do) | (~pin_oe & ext);

    pinbank_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_di(pin_di), .ded_di(ded_ext),
        .pin_oe(pin_oe), .pin_do(pin_do), .seg_sel(seg_sel),
        .cnt0_clk(cnt0_clk), .cnt1_clk(cnt1_clk), .irq_hi(irq_hi)
    );

    // Vector: {pad[4:0] (31 = dedicated), code[2:0], level, exp {cnt0,cnt1,irq}}
    localparam logic [11:0] VEC [12] = '{
        {5'd2,  3'd2, 1'b1, 3'b100}, {5'd11, 3'd3, 1'b1, 3'b010},
        {5'd5,  3'd4, 1'b1, 3'b001}, {5'd31, 3'd2, 1'b1, 3'b100},
        {5'd31, 3'd4, 1'b1, 3'b001}, {5'd7,  3'd1, 1'b1, 3'b000},
        {5'd8,  3'd5, 1'b1, 3'b000}, {5'd9,  3'd7, 1'b1, 3'b000},
        {5'd3,  3'd2, 1'b0, 3'b000}, {5'd12, 3'd2, 1'b1, 3'b000},
        {5'd1,  3'd3, 1'b1, 3'b000}, {5'd10, 3'd3, 1'b1, 3'b010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] res();
        return {29'd0, cnt0_clk, cnt1_clk, irq_hi};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        chk("R7 oe", pin_oe, 0);
        chk("R7 seg", seg_sel, 0);
        chk("R7 do", pin_do, 0);
        settle();
        chk("R7 res", res(), 0);

        // Table walk: routing codes (R4) and unroutable pads (R10)
        for (int v = 0; v < 12; v++) begin
            logic [4:0] pn;
            logic [2:0] code, exp;
            logic lvl;
            pn = VEC[v][11:7]; code = VEC[v][6:4]; lvl = VEC[v][3]; exp = VEC[v][2:0];
            if (pn == 5'd31) begin
                wr(4'd14, N'(code)); ded_ext = lvl;
            end else begin
                if (pn >= 2 && pn <= 11) wr(4'(4 + pn - 2), N'(code));
                ext[pn] = lvl;
            end
            settle();
            chk((pn == 31 || (pn >= 2 && pn <= 11)) ? "R4 route" : "R10 no route",
                res(), {29'd0, exp});
            if (pn == 5'd31) wr(4'd14, '0);
            else if (pn >= 2 && pn <= 11) wr(4'(4 + pn - 2), '0);
            ext = '0; ded_ext = 1'b0;
            settle();
        end

        // R7: port enable releases the low group
        wr(4'd3, 24'd1);
        chk("R7 port_en", pin_oe, 24'h00FFFF);
        // R2: direction and data
        wr(4'd1, 24'hF0000F);
        chk("R2 dir", pin_oe, 24'hF0000F);
        wr(4'd2, 24'hA5A5A5);
        chk("R2 data", pin_do, 24'hA5A5A5);
        // R1, R3: segment mode takes the drive away
        wr(4'd0, 24'h10000F);
        chk("R1 seg_sel", seg_sel, 24'h10000F);
        chk("R3 oe", pin_oe, 24'hE00000);
        wr(4'd0, '0);

        // R8: a driving pad routes its own value
        wr(4'd1, 24'h000010); wr(4'd2, 24'h000010); wr(4'd6, 24'd3);
        settle();
        chk("R8 track hi", res(), 32'b010);
        wr(4'd2, '0);
        settle();
        chk("R8 track lo", res(), 0);
        wr(4'd6, '0); wr(4'd1, '0);

        // R9: a segment-mode pad is ignored by routing
        wr(4'd8, 24'd2); ext[6] = 1'b1; wr(4'd0, 24'h000040);
        settle();
        chk("R9 seg ignored", res(), 0);
        wr(4'd0, '0);
        settle();
        chk("R9 digital again", res(), 32'b100);
        wr(4'd8, '0); ext = '0;

        // R5: OR of pads on the same resource
        wr(4'd4, 24'd4); wr(4'd5, 24'd4); ext[2] = 1'b1;
        settle();
        chk("R5 or one", res(), 32'b001);
        ext[2] = 1'b0;
        settle();
        chk("R5 or none", res(), 0);
        wr(4'd14, 24'd4); ded_ext = 1'b1;
        settle();
        chk("R5 or dedicated", res(), 32'b001);
        ded_ext = 1'b0; wr(4'd14, '0); wr(4'd4, '0); wr(4'd5, '0);

        // R6: two-edge latency
        wr(4'd4, 24'd2);
        settle();
        ext[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R6 after one edge", res(), 0);
        @(posedge clk); @(negedge clk);
        chk("R6 after two edges", res(), 32'b100);
        ext = '0; wr(4'd4, '0);

        // R7: port disable silences the low group again
        wr(4'd1, 24'hFFFFFF); wr(4'd3, '0);
        chk("R7 port off", pin_oe, 24'hFF0000);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule